// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplexer Modes

This block keeps eight single-bit storage cells that share one data input. A binary select picks one cell, and an active-low enable lets that cell take the data value. An active-low clear input works together with the enable to choose one of four modes:

- **Write:** the selected cell loads the data bit.
- **Hold:** every cell keeps its value.
- **Demultiplex:** the data bit is routed to the selected output and all other outputs are low.
- **Clear:** all outputs are forced low.

The stored cells are edge-triggered flops on a system clock. While the enable is low, the selected cell samples the data bit on every rising clock edge. When the enable goes high, the cell keeps the value it sampled at the last edge before that. The clear input resets the cells asynchronously. While the clear input is low, the outputs are produced combinationally from the data and select inputs, so demultiplex and clear take effect at once, with no clock edge.

Typical uses are a bank of individually settable control bits, a serial-to-parallel holding register that is filled one address at a time, or a one-hot strobe generator.

Top module: `addr_latch_demux`

## Requirements
- R1: With clear low and enable high, every bit of `q` is 0 whatever `sel` and `din` are. The clear acts without any clock edge, including when it falls in the middle of a clock period.
- R2: With clear high and enable low at a rising clock edge, bit `sel` of `q` takes the value of `din` after that edge. All other bits keep their values.
- R3: With clear high and enable high at a rising clock edge, `q` keeps its value across that edge, whatever `sel` and `din` do.
- R4: With clear low and enable low, `q` equals `din` in bit `sel` and 0 in every other bit. `q` follows `din` and `sel` combinationally.
- R5: `sel` is an unsigned binary index with bit 0 as the least significant bit. Value 0 addresses `q[0]` and value 7 addresses `q[7]`.
- R6: While clear is low in either mode, all stored bits are reset. After clear returns high, `q` reads all zeros until the next write.
- R7: After a write, raising the enable leaves the addressed bit at the last `din` sampled while the enable was low. Select changes while the enable is high corrupt no bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; writes happen on its rising edge |
| clr_n | input | 1 | Active-low asynchronous clear / mode select |
| en_n | input | 1 | Active-low write enable / mode select |
| din | input | 1 | Shared data bit |
| sel | input | ADDR_W (3) | Binary index of the addressed bit |
| q | output | 2**ADDR_W (8) | Output bits |

## Verification
A wrong stored bit stays hidden while clear is low, because `q` is then driven combinationally. It shows up in the first sample after clear is released and a hold cycle follows, or it shows as a wrong neighbouring bit one cycle after any write. A decode error in the select path shows at once in demultiplex mode as a misplaced or extra high bit. For that reason, every select value is swept in both write mode and demultiplex mode. A clear that is not truly asynchronous shows within the same clock period. The bench checks this by pulling clear low halfway through a period and sampling `q` before the next edge.

// File: rtl/addr_latch_demux.sv
module addr_latch_demux #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              en_n,
  input  logic              din,
  input  logic [ADDR_W-1:0] sel,
  output logic [(1<<ADDR_W)-1:0] q
);
  localparam int N = 1 << ADDR_W;

  logic [N-1:0] cells;
  logic [N-1:0] hit;
  logic [N-1:0] routed;

  assign hit    = N'(1) << sel;
  assign routed = din ? hit : '0;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)
      cells <= '0;
    else if (!en_n)
      cells <= (cells & ~hit) | routed;
  end

  assign q = clr_n ? cells : (en_n ? '0 : routed);
endmodule

// File: rtl/addr_latch_demux_chk.sv
module addr_latch_demux_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              clr_n,
  input logic              en_n,
  input logic              din,
  input logic [ADDR_W-1:0] sel,
  input logic [(1<<ADDR_W)-1:0] q
);
  logic prev_clr;

  always_ff @(negedge clk) prev_clr <= clr_n;

  AST_WRITE_TRACK: assert property (@(posedge clk) disable iff (!clr_n)
    !en_n |=> q[$past(sel)] == $past(din)); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!clr_n)
    en_n |=> $stable(q)); // R3

  always @(negedge clk) begin
    if (!clr_n && en_n)
      AST_CLEAR_LOW: assert (q == '0); // R1
    if (!clr_n)
      AST_DEMUX_ONEHOT: assert ($countones(q) <= 1); // R4
    if (!clr_n && !en_n)
      AST_DEMUX_ROUTE: assert ((q != '0) == din && (!din || q[sel])); // R5
    if (prev_clr === 1'b0 && clr_n && en_n)
      AST_RELEASE_ZERO: assert (q == '0); // R6
  end
endmodule

bind addr_latch_demux addr_latch_demux_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .clr_n(clr_n), .en_n(en_n), .din(din), .sel(sel), .q(q)
);

// File: tb/addr_latch_demux_tb_top.sv
module addr_latch_demux_tb_top;
  localparam int AW = 3;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          clr_n = 1'b0;
  logic          en_n  = 1'b1;
  logic          din   = 1'b0;
  logic [AW-1:0] sel   = '0;
  logic [N-1:0]  q;

  addr_latch_demux #(.ADDR_W(AW)) dut_i (
    .clk(clk), .clr_n(clr_n), .en_n(en_n), .din(din), .sel(sel), .q(q)
  );

  typedef struct { logic [N-1:0] exp; string tag; } item_t;
  item_t sb[$];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [N-1:0]  mstore = '0;
  logic          p_clr = 1'b0, p_en = 1'b1, p_din = 1'b0;
  logic [AW-1:0] p_sel = '0;

  task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string mode_tag(input logic c, input logic e);
    if (c && !e) return "R2";
    if (c && e)  return "R3";
    if (!c && !e) return "R4";
    return "R1";
  endfunction

  task automatic apply_edge();
    @(posedge clk);
    if (p_clr && !p_en) mstore[p_sel] = p_din;
  endtask

  task automatic drive(input logic c, input logic e, input logic d,
                       input logic [AW-1:0] s, input string tag);
    item_t it;
    apply_edge();
    #3;
    clr_n = c; en_n = e; din = d; sel = s;
    if (!c) mstore = '0;
    it.exp = c ? mstore : (e ? '0 : (d ? (N'(1) << s) : '0));
    it.tag = (tag == "") ? mode_tag(c, e) : tag;
    sb.push_back(it);
    p_clr = c; p_en = e; p_din = d; p_sel = s;
  endtask

  task automatic clear_pulse(input logic d, input logic [AW-1:0] s);
    item_t it;
    apply_edge();
    #3;
    clr_n = 1'b1; en_n = 1'b1; din = d; sel = s;
    it.exp = '0; it.tag = "R1";
    sb.push_back(it);
    #5 clr_n = 1'b0;
    mstore = '0;
    #2 chk(q, '0, "R1 async mid-cycle clear");
    p_clr = 1'b0; p_en = 1'b1; p_din = d; p_sel = s;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #15;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        chk(q, it.exp, it.tag);
      end
    end
  end

  initial begin : stim
    logic c, e;
    #5 chk(q, '0, "R1 reset state");
    drive(0, 1, 1, 3'd5, "R1");
    drive(1, 1, 1, 3'd2, "R6");
    for (int i = 0; i < N; i++) drive(1, 0, 1, AW'(i), "R5");
    drive(1, 1, 0, 3'd0, "R3");
    for (int i = 0; i < N; i += 2) drive(1, 0, 0, AW'(i), "R2");
    drive(1, 0, 1, 3'd3, "R2");
    drive(1, 1, 0, 3'd3, "R7");
    for (int i = 0; i < N; i++) drive(1, 1, ~i[0], AW'(i), "R7");
    for (int i = 0; i < N; i++) drive(0, 0, 1, AW'(i), "R5");
    drive(0, 0, 0, 3'd6, "R4");
    drive(1, 1, 1, 3'd7, "R6");
    drive(1, 0, 1, 3'd4, "R2");
    clear_pulse(1'b1, 3'd4);
    drive(1, 1, 0, 3'd1, "R6");
    for (int k = 0; k < 400; k++) begin
      c = ($urandom_range(0, 3) != 0);
      e = $urandom_range(0, 1) == 1;
      if (k % 37 == 36) clear_pulse(1'($urandom_range(0, 1)), AW'($urandom_range(0, N-1)));
      else drive(c, e, 1'($urandom_range(0, 1)), AW'($urandom_range(0, N-1)), "");
    end
    @(posedge clk);
    #16;
    while (sb.size() > 0) @(posedge clk);
    #16;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule